// File: doc/BRIEF.md
# Adaptive Supply and Prediction-Strength Controller

This block controls the core supply code sent to an external regulator. It also sets, for each group of monitored critical paths, how many transition detectors feed the predicted-error reduction. After reset the processor is held while it runs a loop that toggles its critical paths. The supply code falls one step per timer interval until a detected timing error arrives. The group that reported that error then has its detector enable level raised one step per interval, until a predicted error from that group shows that prediction now covers it. The processor's done signal ends this first calibration and releases the processor.

During normal running, a rate monitor counts predicted-error cycles in fixed windows. When a window holds more errors than the preset share allows, the controller raises an interrupt, holds the processor and recalibrates. It spends one interval watching for detected errors. If none arrive, predictions were too pessimistic, so the offending group's level is lowered step by step while its predictions continue. If detected errors do arrive, the supply is raised step by step, and the offending group's level is then cleared and scaled up again. One supply step stands for 30 mV at the regulator.

Top module: `adaptiveVpCtrl`

## Requirements
- R1: Reset state: `vCode` equals `V_INIT`, every group level is 0 (`grpEn` all zero), `calibrated` is zero, `irq` is low, and `cpuHold` and `busy` are high.
- R2: In the initial descent, `vCode` falls by one at the end of every `STEP_CYC`-cycle interval. This continues until a detected error arrives.
- R3: `vCode` never goes below the `vMinLimit` input or above the `vMaxLimit` input. A step that would cross either limit leaves the code unchanged.
- R4: A detected error in the initial phase selects group `detGrp`. That group's level then rises by one at the end of each interval, unless a predicted error hit that group during the interval. A hit ends the climb and sets `calibrated[g]`. A level that has reached `GRP_W` ends the climb without setting the flag. Group g owns bits `grpEn[g*GRP_W +: GRP_W]`, and level k sets the low k bits of that field.
- R5: A predicted error whose hit vector does not include the selected group does not stop that group's climb.
- R6: After a climb in the initial phase ends, `vCode` stays put. A further detected error starts a climb for the group it names.
- R7: `calDone` during the initial phase drops `cpuHold` and `busy` at the next clock edge and clears the rate monitor.
- R8: While running, predicted-error cycles are counted in windows of `WIN_CYC` cycles, and the count clears at each window end. The limit is WIN_CYC*RATE_PCT/100. A predicted error that arrives while the count already equals the limit raises `irq` for exactly one cycle and raises `cpuHold`.
- R9: The offending group is the lowest-index set bit of `predHit` at the latest predicted error seen while running.
- R10: Recalibration without a detected error in its first interval lowers the offending group's level by one per interval, as long as that group was hit during the interval and its level is nonzero. The first interval without a hit returns the controller to running.
- R11: Recalibration with a detected error in its first interval raises `vCode` by one at that interval's end. It raises it again after each later interval that also sees a detected error. The first quiet interval clears the offending group's level and climbs it as in R4, and the end of that climb returns the controller to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vMinLimit | input | VCODE_W | Lowest allowed supply code |
| vMaxLimit | input | VCODE_W | Highest allowed supply code |
| predErr | input | 1 | Predicted timing error this cycle |
| predHit | input | NUM_GROUPS | Groups contributing to the predicted error |
| detErr | input | 1 | Detected timing error this cycle |
| detGrp | input | GIW | Group index of the detected error |
| calDone | input | 1 | Processor finished the critical-path loop |
| vCode | output | VCODE_W | Supply code to the regulator |
| grpEn | output | NUM_GROUPS*GRP_W | Thermometer detector enables per group |
| irq | output | 1 | One-cycle recalibration interrupt |
| cpuHold | output | 1 | Hold processor execution |
| busy | output | 1 | Calibration in progress |
| calibrated | output | NUM_GROUPS | Group reached prediction coverage |

## Verification
Every action happens at the edge that closes an interval. The interval timer restarts at each change of phase, so with a 4-cycle interval a supply or level change is due four edges after the phase began or after the previous change. The bench counts edges from a known reference, such as the reset release or the edge that sampled a stimulus. It drives each stimulus at a falling edge and reads results at the falling edge right after the expected rising edge. `irq`, the release of `cpuHold` on `calDone`, and the overflow are due on the edge that samples their cause. The window boundary is checked by placing errors on the last edge of one window and the first edges of the next.

// File: rtl/avcPkg.sv
package avcPkg;

  typedef enum logic [2:0] {
    S_DESCEND,
    S_CLIMB,
    S_SETTLE,
    S_RUN,
    S_OBSERVE,
    S_RAISE,
    S_RELAX
  } avcStateT;

  typedef struct packed {
    logic vDown;
    logic vUp;
    logic lvlUp;
    logic lvlDown;
    logic lvlClr;
    logic markCal;
    logic monClr;
  } avcStrobeT;

endpackage

// File: rtl/avcRateMon.sv
module avcRateMon #(
  parameter int WIN_CYC = 1000,
  parameter int LIMIT   = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic clr,
  input  logic predErr,
  output logic overflow
);
  localparam int WIN_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam int CNT_W = $clog2(LIMIT + 2);

  logic [WIN_W-1:0] winCnt;
  logic [CNT_W-1:0] errCnt;
  logic             winEnd;

  assign winEnd   = (winCnt == WIN_W'(WIN_CYC - 1));
  assign overflow = en && predErr && (errCnt == CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      winCnt <= '0;
      errCnt <= '0;
    end else if (en && !overflow) begin
      if (winEnd) begin
        winCnt <= '0;
        errCnt <= '0;
      end else begin
        winCnt <= winCnt + WIN_W'(1);
        errCnt <= errCnt + CNT_W'(predErr);
      end
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= CNT_W'(LIMIT));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !clr) |=> $stable(errCnt));

endmodule

// File: rtl/avcDatapath.sv
module avcDatapath
  import avcPkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GRP_W      = 3,
  parameter int VCODE_W    = 6,
  parameter int V_INIT     = 40,
  parameter int GIW        = 2,
  parameter int LVL_W      = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  avcStrobeT                   stb,
  input  logic [GIW-1:0]              curGrp,
  input  logic [VCODE_W-1:0]          vMin,
  input  logic [VCODE_W-1:0]          vMax,
  output logic [VCODE_W-1:0]          vCode,
  output logic [NUM_GROUPS*GRP_W-1:0] grpEn,
  output logic [NUM_GROUPS-1:0]       calibrated,
  output logic [LVL_W-1:0]            curLvl
);
  logic [NUM_GROUPS*LVL_W-1:0] lvlFlat;

  // Supply code with saturation at the programmable limits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vCode <= VCODE_W'(V_INIT);
    end else if (stb.vDown && (vCode > vMin)) begin
      vCode <= vCode - VCODE_W'(1);
    end else if (stb.vUp && (vCode < vMax)) begin
      vCode <= vCode + VCODE_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    logic [LVL_W-1:0] lvlQ;
    logic             calQ;
    logic             sel;

    assign sel = (curGrp == GIW'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvlQ <= '0;
        calQ <= 1'b0;
      end else if (sel) begin
        if (stb.lvlClr) begin
          lvlQ <= '0;
        end else if (stb.lvlUp && (lvlQ < LVL_W'(GRP_W))) begin
          lvlQ <= lvlQ + LVL_W'(1);
        end else if (stb.lvlDown && (lvlQ != '0)) begin
          lvlQ <= lvlQ - LVL_W'(1);
        end
        if (stb.markCal) calQ <= 1'b1;
      end
    end

    assign lvlFlat[g*LVL_W +: LVL_W] = lvlQ;
    assign calibrated[g]             = calQ;

    for (genvar b = 0; b < GRP_W; b++) begin : gBit
      assign grpEn[g*GRP_W + b] = (lvlQ > LVL_W'(b));
    end

    p_lvl_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
      (sel && stb.lvlUp && !stb.lvlClr && lvlQ == LVL_W'(GRP_W)) |=> (lvlQ == LVL_W'(GRP_W)));

    p_lvl_floor_r10: assert property (@(posedge clk) disable iff (!rstN)
      (sel && stb.lvlDown && !stb.lvlClr && !stb.lvlUp && lvlQ == '0) |=> (lvlQ == '0));
  end

  always_comb begin
    curLvl = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (curGrp == GIW'(g)) curLvl = lvlFlat[g*LVL_W +: LVL_W];
    end
  end

  p_vstep_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (vCode == $past(vCode) || vCode == $past(vCode) + VCODE_W'(1) ||
              vCode == $past(vCode) - VCODE_W'(1)));

  p_vfloor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vDown && vCode <= vMin) |=> $stable(vCode));

  p_vceil_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vUp && !stb.vDown && vCode >= vMax) |=> $stable(vCode));

endmodule

// File: rtl/avcCtrl.sv
module avcCtrl
  import avcPkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GRP_W      = 3,
  parameter int STEP_CYC   = 256,
  parameter int GIW        = 2,
  parameter int LVL_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  predErr,
  input  logic [NUM_GROUPS-1:0] predHit,
  input  logic                  detErr,
  input  logic [GIW-1:0]        detGrp,
  input  logic                  calDone,
  input  logic                  overflow,
  input  logic [LVL_W-1:0]      curLvl,
  output avcStrobeT             stb,
  output logic [GIW-1:0]        curGrp,
  output logic                  monEn,
  output logic                  irq,
  output logic                  hold
);
  localparam int TMR_W = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;

  avcStateT         state, stateNext;
  logic [TMR_W-1:0] tmr;
  logic             tick;
  logic             evtSeen, evtNow, seenNow;
  logic             inRecal, recalNext;
  logic [GIW-1:0]   grpNext;
  logic             irqNext;
  logic             grpHit;

  function automatic logic [GIW-1:0] lowestIdx(input logic [NUM_GROUPS-1:0] v);
    logic [GIW-1:0] r;
    r = '0;
    for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
      if (v[i]) r = GIW'(i);
    end
    return r;
  endfunction

  assign tick   = (tmr == TMR_W'(STEP_CYC - 1));
  assign grpHit = predErr && predHit[curGrp];

  always_comb begin
    case (state)
      S_OBSERVE, S_RAISE: evtNow = detErr;
      S_CLIMB, S_RELAX:   evtNow = grpHit;
      default:            evtNow = 1'b0;
    endcase
  end
  assign seenNow = evtSeen || evtNow;

  always_comb begin
    stateNext = state;
    stb       = '0;
    grpNext   = curGrp;
    recalNext = inRecal;
    irqNext   = 1'b0;
    case (state)
      S_DESCEND: begin
        if (calDone) begin
          stateNext  = S_RUN;
          stb.monClr = 1'b1;
        end else if (detErr) begin
          stateNext = S_CLIMB;
          grpNext   = detGrp;
        end else if (tick) begin
          stb.vDown = 1'b1;
        end
      end
      S_CLIMB: begin
        if (calDone && !inRecal) begin
          stateNext  = S_RUN;
          stb.monClr = 1'b1;
        end else if (tick) begin
          if (seenNow || curLvl == LVL_W'(GRP_W)) begin
            stb.markCal = seenNow;
            if (inRecal) begin
              stateNext  = S_RUN;
              stb.monClr = 1'b1;
              recalNext  = 1'b0;
            end else begin
              stateNext = S_SETTLE;
            end
          end else begin
            stb.lvlUp = 1'b1;
          end
        end
      end
      S_SETTLE: begin
        if (calDone) begin
          stateNext  = S_RUN;
          stb.monClr = 1'b1;
        end else if (detErr) begin
          stateNext = S_CLIMB;
          grpNext   = detGrp;
        end
      end
      S_RUN: begin
        if (predErr && (|predHit)) grpNext = lowestIdx(predHit);
        if (overflow) begin
          stateNext = S_OBSERVE;
          irqNext   = 1'b1;
          recalNext = 1'b1;
        end
      end
      S_OBSERVE: begin
        if (tick) begin
          if (seenNow) begin
            stb.vUp   = 1'b1;
            stateNext = S_RAISE;
          end else begin
            stateNext = S_RELAX;
          end
        end
      end
      S_RAISE: begin
        if (tick) begin
          if (seenNow) begin
            stb.vUp = 1'b1;
          end else begin
            stb.lvlClr = 1'b1;
            stateNext  = S_CLIMB;
          end
        end
      end
      S_RELAX: begin
        if (tick) begin
          if (seenNow && curLvl != '0) begin
            stb.lvlDown = 1'b1;
          end else begin
            stateNext  = S_RUN;
            stb.monClr = 1'b1;
            recalNext  = 1'b0;
          end
        end
      end
      default: stateNext = S_DESCEND;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_DESCEND;
      tmr     <= '0;
      evtSeen <= 1'b0;
      curGrp  <= '0;
      inRecal <= 1'b0;
      irq     <= 1'b0;
    end else begin
      state   <= stateNext;
      curGrp  <= grpNext;
      inRecal <= recalNext;
      irq     <= irqNext;
      if (stateNext != state || tick) begin
        tmr     <= '0;
        evtSeen <= 1'b0;
      end else begin
        tmr     <= tmr + TMR_W'(1);
        evtSeen <= seenNow;
      end
    end
  end

  assign monEn = (state == S_RUN);
  assign hold  = (state != S_RUN);

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> hold);

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && (state == S_DESCEND || state == S_SETTLE)) |=> !hold);

  p_single_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.vUp, stb.vDown, stb.lvlUp, stb.lvlDown, stb.lvlClr}));

endmodule

// File: rtl/adaptiveVpCtrl.sv
module adaptiveVpCtrl
  import avcPkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GRP_W      = 3,
  parameter int VCODE_W    = 6,
  parameter int V_INIT     = 40,
  parameter int STEP_CYC   = 256,
  parameter int WIN_CYC    = 1000,
  parameter int RATE_PCT   = 5,
  localparam int GIW       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int LVL_W     = $clog2(GRP_W + 1),
  localparam int LIMIT     = (WIN_CYC * RATE_PCT) / 100
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [VCODE_W-1:0]          vMinLimit,
  input  logic [VCODE_W-1:0]          vMaxLimit,
  input  logic                        predErr,
  input  logic [NUM_GROUPS-1:0]       predHit,
  input  logic                        detErr,
  input  logic [GIW-1:0]              detGrp,
  input  logic                        calDone,
  output logic [VCODE_W-1:0]          vCode,
  output logic [NUM_GROUPS*GRP_W-1:0] grpEn,
  output logic                        irq,
  output logic                        cpuHold,
  output logic                        busy,
  output logic [NUM_GROUPS-1:0]       calibrated
);
  avcStrobeT        stb;
  logic [GIW-1:0]   curGrp;
  logic [LVL_W-1:0] curLvl;
  logic             monEn;
  logic             overflow;
  logic             hold;

  avcCtrl #(
    .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .STEP_CYC(STEP_CYC),
    .GIW(GIW), .LVL_W(LVL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .predErr(predErr), .predHit(predHit),
    .detErr(detErr), .detGrp(detGrp), .calDone(calDone),
    .overflow(overflow), .curLvl(curLvl), .stb(stb), .curGrp(curGrp),
    .monEn(monEn), .irq(irq), .hold(hold)
  );

  avcDatapath #(
    .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .VCODE_W(VCODE_W),
    .V_INIT(V_INIT), .GIW(GIW), .LVL_W(LVL_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .curGrp(curGrp),
    .vMin(vMinLimit), .vMax(vMaxLimit), .vCode(vCode), .grpEn(grpEn),
    .calibrated(calibrated), .curLvl(curLvl)
  );

  avcRateMon #(
    .WIN_CYC(WIN_CYC), .LIMIT(LIMIT)
  ) i_mon (
    .clk(clk), .rstN(rstN), .en(monEn), .clr(stb.monClr),
    .predErr(predErr), .overflow(overflow)
  );

  assign cpuHold = hold;
  assign busy    = hold;

endmodule

// File: tb/test_adaptiveVpCtrl.sv
`timescale 1ns/1ps
module test_adaptiveVpCtrl;
  localparam int G = 4, W = 3, VW = 6, VI = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [VW-1:0] vMinLimit = 6'd37;
  logic [VW-1:0] vMaxLimit = 6'd44;
  logic          predErr = 1'b0;
  logic [G-1:0]  predHit = '0;
  logic          detErr = 1'b0;
  logic [1:0]    detGrp = '0;
  logic          calDone = 1'b0;
  logic [VW-1:0] vCode;
  logic [G*W-1:0] grpEn;
  logic          irq, cpuHold, busy;
  logic [G-1:0]  calibrated;

  int nChk = 0;
  int nErr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adaptiveVpCtrl #(
    .NUM_GROUPS(G), .GRP_W(W), .VCODE_W(VW), .V_INIT(VI),
    .STEP_CYC(4), .WIN_CYC(20), .RATE_PCT(25)
  ) i_adaptiveVpCtrl (
    .clk(clk), .rstN(rstN), .vMinLimit(vMinLimit), .vMaxLimit(vMaxLimit),
    .predErr(predErr), .predHit(predHit), .detErr(detErr), .detGrp(detGrp),
    .calDone(calDone), .vCode(vCode), .grpEn(grpEn), .irq(irq),
    .cpuHold(cpuHold), .busy(busy), .calibrated(calibrated)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int field(input int g);
    return int'(grpEn[g*W +: W]);
  endfunction

  function automatic int therm(input int k);
    return (1 << k) - 1;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    // R1 reset state, before the first edge after release
    chk("R1 vCode", vCode, VI);
    chk("R1 grpEn", grpEn, 0);
    chk("R1 calibrated", calibrated, 0);
    chk("R1 irq", irq, 0);
    chk("R1 hold", cpuHold, 1);
    chk("R1 busy", busy, 1);

    // R2 descent, R3 floor at vMinLimit=37
    for (int k = 1; k <= 5; k++) begin
      cyc(4);
      chk("R2/R3 descent", vCode, (VI - k < 37) ? 37 : VI - k);
    end

    // R4 detected error on group 2 starts the climb
    detErr = 1'b1; detGrp = 2'd2;
    cyc(1); detErr = 1'b0;
    cyc(4); chk("R4 level 1", field(2), therm(1));
    cyc(1); predErr = 1'b1; predHit = 4'b0010;       // R5 other group
    cyc(1); predErr = 1'b0; predHit = '0;
    cyc(2); chk("R5 foreign hit ignored", field(2), therm(2));
    cyc(1); predErr = 1'b1; predHit = 4'b0100;
    cyc(1); predErr = 1'b0; predHit = '0;
    cyc(2);
    chk("R4 level held", field(2), therm(2));
    chk("R4 calibrated", calibrated, 4'b0100);
    cyc(8);
    chk("R6 voltage kept", vCode, 37);
    chk("R6 still held", cpuHold, 1);

    // R6 second group, climb to saturation without a hit
    detErr = 1'b1; detGrp = 2'd0;
    cyc(1); detErr = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      cyc(4);
      chk("R6/R4 group0 climb", field(0), therm(k));
    end
    cyc(4);
    chk("R4 saturated level", field(0), therm(3));
    chk("R4 unmarked at cap", calibrated, 4'b0100);

    // R7 release
    calDone = 1'b1;
    cyc(1); calDone = 1'b0;
    chk("R7 hold released", cpuHold, 0);
    chk("R7 busy released", busy, 0);

    // R8 window: 5 at the end of window 0, 5 in window 1, the 6th overflows
    cyc(15);
    predErr = 1'b1; predHit = 4'b0100;
    for (int i = 1; i <= 11; i++) begin
      cyc(1);
      chk("R8 irq vs window count", irq, (i == 11) ? 1 : 0);
    end
    predErr = 1'b0; predHit = '0;
    chk("R8 hold on overflow", cpuHold, 1);
    cyc(1);
    chk("R8 irq one cycle", irq, 0);

    // R10 recalibration without detected error: group 2 relaxes 2 -> 1
    vMaxLimit = 6'd38;
    cyc(4); predErr = 1'b1; predHit = 4'b0100;
    cyc(1); predErr = 1'b0; predHit = '0;
    cyc(2);
    chk("R10 lowered", field(2), therm(1));
    chk("R10 still held", cpuHold, 1);
    cyc(4);
    chk("R10 back to run", cpuHold, 0);
    chk("R10 level kept", field(2), therm(1));
    chk("R10 voltage kept", vCode, 37);

    // R9 / R11: overflow with hits on groups 0 and 1 -> group 0 offends
    predErr = 1'b1; predHit = 4'b0011;
    cyc(6); predErr = 1'b0; predHit = '0;
    chk("R8 second overflow", irq, 1);
    cyc(1); detErr = 1'b1; detGrp = 2'd3;
    cyc(1); detErr = 1'b0;
    cyc(2); chk("R11 first raise", vCode, 38);
    cyc(1); detErr = 1'b1;
    cyc(1); detErr = 1'b0;
    cyc(2); chk("R3 ceiling at vMaxLimit", vCode, 38);
    cyc(4);
    chk("R9/R11 offender cleared", field(0), 0);
    chk("R11 other group untouched", field(2), therm(1));
    cyc(4); chk("R11 re-climb", field(0), therm(1));
    cyc(1); predErr = 1'b1; predHit = 4'b0001;
    cyc(1); predErr = 1'b0; predHit = '0;
    cyc(2);
    chk("R11 calibrated", calibrated, 4'b0101);
    chk("R11 level final", field(0), therm(1));
    chk("R11 resumed", cpuHold, 0);
    chk("R11 voltage final", vCode, 38);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule